// File: doc/BRIEF.md
# External Master Access Bridge

This block lets a bus master outside the chip reach slaves on the chip's internal bus. It watches an external bus with a simple start/acknowledge handshake, decodes whether each address lies in the relocatable internal window, and forwards single transfers of 8, 16 or 32 bits onto the internal bus. Every access it claims ends with exactly one terminating pulse: acknowledge, error, or back-off (retry).

The block holds its own control register inside the window. This register selects the operating mode, the window base and the one-shot redirection of the next access into the special-register map. In slave mode the local CPU keeps running and shares the internal bus through an external arbiter. If the CPU has an outbound access pending when the external master starts, the block backs the master off. In peripheral mode the CPU is held, arbitration is skipped, and the mode can be forced at reset through a strap input. After a back-off the block refuses CPU internal accesses for a fixed window. After each completed access it masks the CPU for a shorter window, so that closely spaced external accesses can follow one another.

Top module: `ext_master_bridge`

## Requirements
- R1: Size code 0 (byte), 1 (halfword) and 2 (word) is forwarded unchanged on `int_size_o`; size code 3 is terminated with `ext_err_o` and no internal request.
- R2: A start with `ext_burst_i` high that hits the window raises `ext_burst_inh_o` together with `ext_err_o` in the next cycle, and issues no internal request.
- R3: An address hits the window when its top WBASE_W bits equal the control field `win_base` (bits 8 and up). A miss gets no termination and no internal request.
- R4: Each claimed access ends with a single one-cycle pulse on exactly one of `ext_ack_o`, `ext_err_o`, `ext_backoff_o`. An internal error ends in `ext_err_o`, and read data is on `ext_rdata_o` in the `ext_ack_o` cycle.
- R5: In slave mode, a hitting start while `cpu_ext_pend_i` is high is answered with `ext_backoff_o` in the next cycle and makes no internal request.
- R6: `cpu_block_o` is high for exactly LOCK_CYC (8) cycles, starting in the `ext_backoff_o` cycle.
- R7: `cpu_block_o` is high for GAP_CYC (4) cycles, starting in the cycle of each `ext_ack_o` or `ext_err_o`.
- R8: Writing the control register with bit 2 (redirect) set and bit 3 (user) clear arms a one-shot. The next forwarded access, even one to the control address, carries `int_spr_o`; later accesses do not. With bit 3 set, nothing is armed.
- R9: In slave mode (bit 0 set, bit 1 clear) a forwarded request holds address and attributes until a cycle with `int_gnt_i` and `int_ack_i`/`int_err_i` both high. `ext_ack_o` follows one cycle later.
- R10: In peripheral mode (bit 1 set) `cpu_halt_o` is high, `int_gnt_i` is not needed and `cpu_ext_pend_i` causes no back-off. Bit 1 resets to `periph_strap_i`.
- R11: A start while `ext_own_i` is low is ignored.
- R12: The control register sits at offset CTRL_OFS inside the window and answers a read or write with `ext_ack_o` one cycle after the start, in any mode. It resets to slave on, redirect off, user on, base 0 (0x9, plus 0x2 when strapped). With bits 0 and 1 both clear, other window accesses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| periph_strap_i | input | 1 | Reset value of the peripheral-mode bit |
| ext_own_i | input | 1 | External master holds bus ownership |
| ext_start_i | input | 1 | One-cycle transfer start |
| ext_addr_i | input | ADDR_W | Transfer address |
| ext_we_i | input | 1 | Write when high |
| ext_size_i | input | 2 | 0 byte, 1 half, 2 word, 3 invalid |
| ext_burst_i | input | 1 | Master requests a burst |
| ext_wdata_i | input | DATA_W | Write data |
| ext_rdata_o | output | DATA_W | Read data |
| ext_ack_o | output | 1 | Transfer acknowledge |
| ext_err_o | output | 1 | Transfer error |
| ext_backoff_o | output | 1 | Release bus and retry later |
| ext_burst_inh_o | output | 1 | Burst refused |
| int_req_o | output | 1 | Internal bus request |
| int_gnt_i | input | 1 | Internal bus grant |
| int_addr_o | output | ADDR_W | Internal address |
| int_we_o | output | 1 | Internal write |
| int_size_o | output | 2 | Internal size code |
| int_wdata_o | output | DATA_W | Internal write data |
| int_spr_o | output | 1 | Access targets special-register map |
| int_ack_i | input | 1 | Internal slave acknowledge |
| int_err_i | input | 1 | Internal slave error |
| int_rdata_i | input | DATA_W | Internal read data |
| cpu_ext_pend_i | input | 1 | CPU has an outbound access pending |
| cpu_block_o | output | 1 | Refuse/mask CPU internal accesses |
| cpu_halt_o | output | 1 | CPU held (peripheral mode) |

## Verification
A stuck access state shows within one cycle: `int_req_o` stays high, or a start goes unanswered within the few cycles the handshake allows. A wrong count in either lockout counter shows as a `cpu_block_o` run of the wrong length, measured from the terminating pulse. A one-shot flag that is lost or left armed shows on `int_spr_o` of the very next forwarded access. A corrupted base or mode field shows on the next control-register read, or as a miss on an address that should hit.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FWD = 1'b1} ebr_state_e;
  typedef enum logic [1:0] {RSP_NONE, RSP_ACK, RSP_ERR, RSP_BACKOFF} ebr_rsp_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  // control register layout
  localparam int BIT_SLAVE  = 0;
  localparam int BIT_PERIPH = 1;
  localparam int BIT_REDIR  = 2;
  localparam int BIT_USER   = 3;
  localparam int BIT_BASE   = 8;
endpackage

// File: rtl/ebr_decode.sv
module ebr_decode #(
  parameter int ADDR_W  = 32,
  parameter int WBASE_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 32'h0030_0000
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WBASE_W-1:0] base_i,
  output logic               hit_o,
  output logic               ctrl_o
);
  localparam int WIN_W = ADDR_W - WBASE_W;

  assign hit_o  = (addr_i[ADDR_W-1 -: WBASE_W] == base_i);
  assign ctrl_o = hit_o && (addr_i[WIN_W-1:0] == CTRL_OFS[WIN_W-1:0]);
endmodule

// File: rtl/ebr_ctrl_reg.sv
module ebr_ctrl_reg
  import ebr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WBASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               periph_strap_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               consume_i,
  output logic               slave_o,
  output logic               periph_o,
  output logic [WBASE_W-1:0] base_o,
  output logic               armed_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic redir_q, user_q;

  // strap is static while reset is asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_o  <= 1'b1;
      periph_o <= periph_strap_i;
      redir_q  <= 1'b0;
      user_q   <= 1'b1;
      base_o   <= '0;
      armed_o  <= 1'b0;
    end else if (we_i) begin
      slave_o  <= wdata_i[BIT_SLAVE];
      periph_o <= wdata_i[BIT_PERIPH];
      redir_q  <= wdata_i[BIT_REDIR];
      user_q   <= wdata_i[BIT_USER];
      base_o   <= wdata_i[BIT_BASE +: WBASE_W];
      armed_o  <= wdata_i[BIT_REDIR] & ~wdata_i[BIT_USER];
    end else if (consume_i) begin
      armed_o  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[BIT_SLAVE]          = slave_o;
    rdata_o[BIT_PERIPH]         = periph_o;
    rdata_o[BIT_REDIR]          = redir_q;
    rdata_o[BIT_USER]           = user_q;
    rdata_o[BIT_BASE +: WBASE_W] = base_o;
  end
endmodule

// File: rtl/ebr_countdown.sv
module ebr_countdown #(
  parameter int CNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int CW = $clog2(CNT + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(CNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= LOAD_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/ext_master_bridge.sv
module ext_master_bridge
  import ebr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WBASE_W  = 3,
  parameter int LOCK_CYC = 8,
  parameter int GAP_CYC  = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 32'h0030_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              periph_strap_i,
  input  logic              ext_own_i,
  input  logic              ext_start_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              ext_we_i,
  input  logic [1:0]        ext_size_i,
  input  logic              ext_burst_i,
  input  logic [DATA_W-1:0] ext_wdata_i,
  output logic [DATA_W-1:0] ext_rdata_o,
  output logic              ext_ack_o,
  output logic              ext_err_o,
  output logic              ext_backoff_o,
  output logic              ext_burst_inh_o,
  output logic              int_req_o,
  input  logic              int_gnt_i,
  output logic [ADDR_W-1:0] int_addr_o,
  output logic              int_we_o,
  output logic [1:0]        int_size_o,
  output logic [DATA_W-1:0] int_wdata_o,
  output logic              int_spr_o,
  input  logic              int_ack_i,
  input  logic              int_err_i,
  input  logic [DATA_W-1:0] int_rdata_i,
  input  logic              cpu_ext_pend_i,
  output logic              cpu_block_o,
  output logic              cpu_halt_o
);
  ebr_state_e state_q, state_d;
  ebr_rsp_e   rsp_q, rsp_d;
  logic       inh_q, inh_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        size_q;
  logic              we_q, spr_q;

  logic slave_en, periph_en, armed, hit, ctrl_hit;
  logic [WBASE_W-1:0] win_base;
  logic [DATA_W-1:0]  ctrl_rdata;
  logic ctrl_we, consume, fwd_d, start, mode_on, slave_act, redirect, done;
  logic lock_act, gap_act;

  ebr_decode #(.ADDR_W(ADDR_W), .WBASE_W(WBASE_W), .CTRL_OFS(CTRL_OFS)) u_dec (
    .addr_i (ext_addr_i),
    .base_i (win_base),
    .hit_o  (hit),
    .ctrl_o (ctrl_hit)
  );

  ebr_ctrl_reg #(.DATA_W(DATA_W), .WBASE_W(WBASE_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .periph_strap_i (periph_strap_i),
    .we_i           (ctrl_we),
    .wdata_i        (ext_wdata_i),
    .consume_i      (consume),
    .slave_o        (slave_en),
    .periph_o       (periph_en),
    .base_o         (win_base),
    .armed_o        (armed),
    .rdata_o        (ctrl_rdata)
  );

  assign mode_on   = slave_en | periph_en;
  assign slave_act = slave_en & ~periph_en;
  assign redirect  = armed & mode_on;
  assign start     = ext_start_i & ext_own_i & (state_q == ST_IDLE) & hit;
  // peripheral mode owns the internal bus outright
  assign done      = (periph_en | int_gnt_i) & (int_ack_i | int_err_i);

  always_comb begin
    state_d = state_q;
    rsp_d   = RSP_NONE;
    inh_d   = 1'b0;
    rdata_d = rdata_q;
    fwd_d   = 1'b0;
    ctrl_we = 1'b0;
    consume = 1'b0;
    if (state_q == ST_FWD) begin
      if (done) begin
        rsp_d   = int_err_i ? RSP_ERR : RSP_ACK;
        rdata_d = int_rdata_i;
        state_d = ST_IDLE;
        consume = spr_q;
      end
    end else if (start) begin
      if (ext_burst_i) begin
        rsp_d = RSP_ERR;
        inh_d = 1'b1;
      end else if (slave_act && cpu_ext_pend_i) begin
        rsp_d = RSP_BACKOFF;
      end else if (ext_size_i == SZ_BAD) begin
        rsp_d = RSP_ERR;
      end else if (ctrl_hit && !redirect) begin
        rsp_d   = RSP_ACK;
        ctrl_we = ext_we_i;
        rdata_d = ext_we_i ? '0 : ctrl_rdata;
      end else if (mode_on) begin
        fwd_d   = 1'b1;
        state_d = ST_FWD;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rsp_q   <= RSP_NONE;
      inh_q   <= 1'b0;
      rdata_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= SZ_WORD;
      we_q    <= 1'b0;
      spr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
      inh_q   <= inh_d;
      rdata_q <= rdata_d;
      if (fwd_d) begin
        addr_q  <= ext_addr_i;
        wdata_q <= ext_wdata_i;
        size_q  <= ext_size_i;
        we_q    <= ext_we_i;
        spr_q   <= redirect;
      end
    end
  end

  ebr_countdown #(.CNT(LOCK_CYC)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rsp_d == RSP_BACKOFF),
    .active_o (lock_act)
  );

  ebr_countdown #(.CNT(GAP_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   ((rsp_d == RSP_ACK) || (rsp_d == RSP_ERR)),
    .active_o (gap_act)
  );

  assign ext_ack_o       = (rsp_q == RSP_ACK);
  assign ext_err_o       = (rsp_q == RSP_ERR);
  assign ext_backoff_o   = (rsp_q == RSP_BACKOFF);
  assign ext_burst_inh_o = inh_q;
  assign ext_rdata_o     = rdata_q;

  assign int_req_o   = (state_q == ST_FWD);
  assign int_addr_o  = addr_q;
  assign int_we_o    = we_q;
  assign int_size_o  = size_q;
  assign int_wdata_o = wdata_q;
  assign int_spr_o   = int_req_o & spr_q;

  assign cpu_block_o = lock_act | gap_act;
  assign cpu_halt_o  = periph_en;
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker #(
  parameter int ADDR_W   = 32,
  parameter int LOCK_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_ack_o,
  input logic              ext_err_o,
  input logic              ext_backoff_o,
  input logic              ext_burst_inh_o,
  input logic              int_req_o,
  input logic              int_ack_i,
  input logic              int_err_i,
  input logic [ADDR_W-1:0] int_addr_o,
  input logic              int_spr_o,
  input logic              cpu_block_o,
  input logic              cpu_halt_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  logic [CW-1:0] win_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             win_cnt <= '0;
    else if (ext_backoff_o)  win_cnt <= CW'(LOCK_CYC - 1);
    else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
  end

  // R4
  one_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_ack_o, ext_err_o, ext_backoff_o}));

  // R2
  inh_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_burst_inh_o |-> ext_err_o);

  // R6
  lock_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_backoff_o || win_cnt != '0) |-> cpu_block_o);

  // R7
  gap_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_ack_o || ext_err_o) |-> cpu_block_o);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_o && !(int_ack_i || int_err_i)) |=>
      (int_req_o && $stable(int_addr_o) && $stable(int_spr_o)));

  // R10
  periph_no_backoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_halt_o |-> !ext_backoff_o);
endmodule

bind ext_master_bridge ebr_checker #(.ADDR_W(ADDR_W), .LOCK_CYC(LOCK_CYC)) u_ebr_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ext_ack_o       (ext_ack_o),
  .ext_err_o       (ext_err_o),
  .ext_backoff_o   (ext_backoff_o),
  .ext_burst_inh_o (ext_burst_inh_o),
  .int_req_o       (int_req_o),
  .int_ack_i       (int_ack_i),
  .int_err_i       (int_err_i),
  .int_addr_o      (int_addr_o),
  .int_spr_o       (int_spr_o),
  .cpu_block_o     (cpu_block_o),
  .cpu_halt_o      (cpu_halt_o)
);

// File: tb/sim_ext_master_bridge.sv
module sim_ext_master_bridge;
  localparam logic [31:0] CTRL_A = 32'h0030_0000;
  localparam logic [31:0] NORM_A = 32'h0000_1000;
  localparam logic [31:0] RD_XOR = 32'h5A5A_0000;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic own = 1'b1, start = 1'b0, we = 1'b0, burst = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0] size = 2'd2;
  logic gnt_en = 1'b1, slv_err = 1'b0, pend = 1'b0;
  logic int_ack = 1'b0, int_err = 1'b0;
  logic [31:0] int_rdata = '0;

  logic [31:0] ext_rdata, int_addr, int_wdata;
  logic ext_ack, ext_err, ext_backoff, ext_inh, int_req, int_we, int_spr, cpu_block, cpu_halt;
  logic [1:0] int_size;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ext_master_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .periph_strap_i(strap),
    .ext_own_i(own), .ext_start_i(start), .ext_addr_i(addr), .ext_we_i(we),
    .ext_size_i(size), .ext_burst_i(burst), .ext_wdata_i(wdata),
    .ext_rdata_o(ext_rdata), .ext_ack_o(ext_ack), .ext_err_o(ext_err),
    .ext_backoff_o(ext_backoff), .ext_burst_inh_o(ext_inh),
    .int_req_o(int_req), .int_gnt_i(gnt_en), .int_addr_o(int_addr), .int_we_o(int_we),
    .int_size_o(int_size), .int_wdata_o(int_wdata), .int_spr_o(int_spr),
    .int_ack_i(int_ack), .int_err_i(int_err), .int_rdata_i(int_rdata),
    .cpu_ext_pend_i(pend), .cpu_block_o(cpu_block), .cpu_halt_o(cpu_halt)
  );

  // internal slave: answers any request seen at the falling edge
  always @(negedge clk) begin
    int_ack   = int_req & ~slv_err;
    int_err   = int_req & slv_err;
    int_rdata = int_addr ^ RD_XOR;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    strap = s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // rsp: 0 none, 1 ack, 2 err, 3 backoff
  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input logic [1:0] s, input logic b,
                        output int rsp, output logic inh, output logic [31:0] rd,
                        output logic sawreq, output logic sawspr,
                        output logic [31:0] raddr, output logic [1:0] rsize);
    rsp = 0; inh = 0; rd = '0; sawreq = 0; sawspr = 0; raddr = '0; rsize = '0;
    @(negedge clk);
    start = 1'b1; addr = a; we = w; wdata = d; size = s; burst = b;
    @(negedge clk);
    start = 1'b0; burst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (i > 0) @(negedge clk);
      if (int_req) begin
        sawreq = 1'b1; raddr = int_addr; rsize = int_size;
        if (int_spr) sawspr = 1'b1;
      end
      inh = ext_inh;
      rd  = ext_rdata;
      if (ext_ack) rsp = 1;
      else if (ext_err) rsp = 2;
      else if (ext_backoff) rsp = 3;
      if (rsp != 0) break;
    end
  endtask

  task automatic block_run(output int n);
    n = 0;
    while (cpu_block && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic ctrl_wr(input logic [31:0] a, input logic [31:0] v, input string req);
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    access(a, 1'b1, v, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk(req, "ctrl write ack", rsp, 1);
  endtask

  task automatic t_reset_state();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    chk("R12", "outputs after reset",
        {ext_ack, ext_err, ext_backoff, ext_inh, int_req, cpu_block, cpu_halt}, '0);
    access(CTRL_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R12", "ctrl read ack", rsp, 1);
    chk("R12", "ctrl reset value", rd, 32'h9);
    chk("R12", "ctrl read is local", sr, 0);
  endtask

  task automatic t_sizes();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    idle(5);
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R4", "word read ack", rsp, 1);
    chk("R4", "word read data", rd, NORM_A ^ RD_XOR);
    chk("R1", "word size code", rs, 2);
    chk("R3", "forwarded address", ra, NORM_A);
    access(NORM_A + 3, 1'b1, 32'h11, 2'd0, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R1", "byte ack", rsp, 1);
    chk("R1", "byte size code", rs, 0);
    access(NORM_A + 2, 1'b0, '0, 2'd1, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R1", "half size code", rs, 1);
    access(NORM_A, 1'b0, '0, 2'd3, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R1", "bad size error", rsp, 2);
    chk("R1", "bad size no request", sr, 0);
  endtask

  task automatic t_burst();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    access(NORM_A, 1'b0, '0, 2'd2, 1'b1, rsp, inh, rd, sr, ss, ra, rs);
    chk("R2", "burst error", rsp, 2);
    chk("R2", "burst inhibit", inh, 1);
    chk("R2", "burst no request", sr, 0);
  endtask

  task automatic t_miss_and_own();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    access(32'h8000_1000, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R3", "miss no termination", rsp, 0);
    chk("R3", "miss no request", sr, 0);
    own = 1'b0;
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    own = 1'b1;
    chk("R11", "no ownership ignored", {rsp[1:0], sr}, 0);
  endtask

  task automatic t_slave_err();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    slv_err = 1'b1;
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    slv_err = 1'b0;
    chk("R4", "internal error maps to err", rsp, 2);
  endtask

  task automatic t_deadlock();
    int rsp, n; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    idle(6);
    pend = 1'b1;
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    pend = 1'b0;
    chk("R5", "backoff on pending cpu access", rsp, 3);
    chk("R5", "backoff no request", sr, 0);
    block_run(n);
    chk("R6", "lockout length", n, 8);
  endtask

  task automatic t_gap();
    int rsp, n; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    idle(10);
    chk("R7", "no block when quiet", cpu_block, 0);
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    block_run(n);
    chk("R7", "gap mask length", n, 4);
  endtask

  task automatic t_slave_gnt();
    gnt_en = 1'b0;
    @(negedge clk);
    start = 1'b1; addr = NORM_A + 32'h40; we = 1'b0; size = 2'd2;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R9", "request held without grant", {int_req, ext_ack, int_addr}, {1'b1, 1'b0, NORM_A + 32'h40});
      @(negedge clk);
    end
    gnt_en = 1'b1;
    @(negedge clk);
    chk("R9", "ack after grant", {ext_ack, int_req}, 2'b10);
    chk("R9", "data after grant", ext_rdata, (NORM_A + 32'h40) ^ RD_XOR);
  endtask

  task automatic t_redirect();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    ctrl_wr(CTRL_A, 32'h5, "R8");
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R8", "first access redirected", {sr, ss}, 2'b11);
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R8", "second access normal", {sr, ss}, 2'b10);
    ctrl_wr(CTRL_A, 32'h5, "R8");
    access(CTRL_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R8", "ctrl address redirected once", {sr, ss}, 2'b11);
    access(CTRL_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R12", "ctrl reachable again", {sr, rd}, {1'b0, 32'h5});
    ctrl_wr(CTRL_A, 32'hD, "R8");
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R8", "user bit blocks redirect", {sr, ss}, 2'b10);
    ctrl_wr(CTRL_A, 32'h9, "R8");
  endtask

  task automatic t_relocate();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    ctrl_wr(CTRL_A, 32'h209, "R3");
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R3", "old window misses", {rsp[1:0], sr}, 0);
    access(32'h4000_1000, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R3", "new window hits", rd, 32'h4000_1000 ^ RD_XOR);
    ctrl_wr(32'h4030_0000, 32'h9, "R3");
  endtask

  task automatic t_disabled();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    ctrl_wr(CTRL_A, 32'h0, "R12");
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R12", "disabled ignores window", {rsp[1:0], sr}, 0);
    access(CTRL_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R12", "disabled ctrl read", {rsp[1:0], rd}, {2'd1, 32'h0});
    ctrl_wr(CTRL_A, 32'h9, "R12");
  endtask

  task automatic t_periph();
    int rsp; logic inh, sr, ss; logic [31:0] rd, ra; logic [1:0] rs;
    do_reset(1'b1);
    chk("R10", "halt from strap", cpu_halt, 1);
    access(CTRL_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    chk("R10", "strapped ctrl value", rd, 32'hB);
    gnt_en = 1'b0;
    pend = 1'b1;
    access(NORM_A, 1'b0, '0, 2'd2, 1'b0, rsp, inh, rd, sr, ss, ra, rs);
    pend = 1'b0;
    gnt_en = 1'b1;
    chk("R10", "no grant, no backoff", rsp, 1);
    chk("R10", "periph read data", rd, NORM_A ^ RD_XOR);
    do_reset(1'b0);
    chk("R10", "halt released", cpu_halt, 0);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset_state();
    t_sizes();
    t_burst();
    t_miss_and_own();
    t_slave_err();
    t_deadlock();
    t_gap();
    t_slave_gnt();
    t_redirect();
    t_relocate();
    t_disabled();
    t_periph();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule